// File: doc/BRIEF.md
# Control Register Bank with Write-Protected RAM

This block puts a few control registers in front of a single-port on-chip RAM of 4096 32-bit words. Both sit behind one synchronous request port. Each cycle the port carries at most one access, and addresses are byte addresses.

Three registers live in a small register window:
- a scratch word, which software uses to check the data lines of the bus;
- a read-only identification word that holds a major and a minor revision number;
- a control/status word whose bit 12 opens or closes write access to the RAM.

The RAM answers in a separate window. It can always be read. It accepts writes only while the control bit is set, so a table loaded at boot can be locked against stray stores.

Every read returns its data with a valid strobe exactly one cycle after the request. This holds for both registers and RAM. A half-word read returns the low 16 bits of the addressed word with the upper half zeroed.

Top module: `periph_regram`

## Requirements
- R1: After reset the scratch and control words read as 0, so RAM writes are blocked until software sets bit 12.
- R2: The scratch word at byte offset 0x50 stores and returns any 32-bit value, including 0x55555555 and 0xAAAAAAAA.
- R3: The word at offset 0x40 reads as {16'h0, major[7:0], minor[7:0]} (major in bits 15:8, minor in bits 7:0), and writes to it change nothing.
- R4: A read with half_i = 1 returns bits 15:0 of the addressed word in rdata_o[15:0] and zero in rdata_o[31:16].
- R5: The control word at offset 0x0C keeps all 32 written bits, so a read-modify-write of bit 12 preserves the other bits.
- R6: A RAM write issued while control bit 12 is 0 leaves the addressed RAM word unchanged.
- R7: RAM reads return the stored word whether bit 12 is set or clear.
- R8: A read request raises rvalid_o together with its data on the next cycle only. A write request or an idle cycle gives rvalid_o = 0 on the next cycle.
- R9: Reads of register-window offsets other than 0x0C, 0x40 and 0x50, or of addresses outside both windows, return 0, and writes there have no effect.
- R10: RAM word n sits at byte address 0x200000 + 4n for n in 0..4095, so its first and last words are independent storage. Address 0x204000 is outside the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| half_i | input | 1 | Half-word read: return low 16 bits |
| addr_i | input | 22 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |

## Verification
The hardest case to reach is a write to RAM that must be ignored. Its effect is invisible unless that word was first loaded with a known value while writes were open.

The stimulus therefore works in four steps:
1. It sets bit 12 together with other control bits and fills chosen RAM words, including the first and last word.
2. It clears bit 12 with a read-modify-write value.
3. It writes a different value to one of those words.
4. It reads that word back, which checks the protection and the preserved control bits together.

// File: rtl/regram_pkg.sv
package regram_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h0C;
  localparam logic [7:0] OFS_VER  = 8'h40;
  localparam logic [7:0] OFS_SCR  = 8'h50;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_VER  = 3'd2,
    SEL_SCR  = 3'd3,
    SEL_RAM  = 3'd4
  } sel_e;
endpackage

// File: rtl/regram_decode.sv
module regram_decode
  import regram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned RAM_BASE  = 32'h0020_0000,
  parameter int unsigned RAM_WORDS = 4096,
  localparam int unsigned RAM_AW   = $clog2(RAM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  localparam int unsigned RAM_BB  = RAM_AW + 2;
  localparam int unsigned TAG_W   = ADDR_W - RAM_BB;
  localparam int unsigned RAM_TAG = RAM_BASE >> RAM_BB;

  logic reg_win;
  logic ram_win;

  assign reg_win    = (addr_i[ADDR_W-1:8] == '0);
  assign ram_win    = (addr_i[ADDR_W-1:RAM_BB] == RAM_TAG[TAG_W-1:0]);
  assign ram_addr_o = addr_i[RAM_BB-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (ram_win) begin
      sel_o = SEL_RAM;
    end else if (reg_win) begin
      unique case ({addr_i[7:2], 2'b00})
        OFS_CTRL: sel_o = SEL_CTRL;
        OFS_VER:  sel_o = SEL_VER;
        OFS_SCR:  sel_o = SEL_SCR;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/regram_regs.sv
module regram_regs
  import regram_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter logic [7:0]  VER_MAJOR = 8'd3,
  parameter logic [7:0]  VER_MINOR = 8'd7,
  parameter int unsigned WEN_BIT   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ram_wen_o
);
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ver_w;

  assign ver_w = DATA_W'({VER_MAJOR, VER_MINOR});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scr_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_SCR)  scr_q  <= wdata_i;
      if (sel_i == SEL_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = ctrl_q;
      SEL_VER:  rdata_o = ver_w;
      SEL_SCR:  rdata_o = scr_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ram_wen_o = ctrl_q[WEN_BIT];
endmodule

// File: rtl/regram_mem.sv
module regram_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4096,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/periph_regram.sv
module periph_regram
  import regram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_BASE  = 32'h0020_0000,
  parameter int unsigned RAM_WORDS = 4096,
  parameter logic [7:0]  VER_MAJOR = 8'd3,
  parameter logic [7:0]  VER_MINOR = 8'd7,
  parameter int unsigned WEN_BIT   = 12,
  localparam int unsigned RAM_AW   = $clog2(RAM_WORDS),
  localparam int unsigned HALF_W   = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              half_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  sel_e              sel;
  logic [RAM_AW-1:0] ram_addr;
  logic              wr;
  logic              rd;
  logic              ram_wen;
  logic              ram_wr;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] full_rdata;

  sel_e              sel_q;
  logic              half_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] reg_rdata_q;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign ram_wr = wr & (sel == SEL_RAM) & ram_wen;

  regram_decode #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS)
  ) u_decode (
    .addr_i(addr_i), .sel_o(sel), .ram_addr_o(ram_addr)
  );

  regram_regs #(
    .DATA_W(DATA_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .WEN_BIT(WEN_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .sel_i(sel),
    .wdata_i(wdata_i), .rdata_o(reg_rdata), .ram_wen_o(ram_wen)
  );

  regram_mem #(
    .DATA_W(DATA_W), .WORDS(RAM_WORDS)
  ) u_mem (
    .clk_i(clk_i), .we_i(ram_wr), .addr_i(ram_addr),
    .wdata_i(wdata_i), .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= SEL_NONE;
      half_q      <= 1'b0;
      rvalid_q    <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) begin
        sel_q       <= sel;
        half_q      <= half_i;
        reg_rdata_q <= reg_rdata;
      end
    end
  end

  assign full_rdata = (sel_q == SEL_RAM) ? ram_rdata : reg_rdata_q;
  assign rdata_o    = half_q ? {{(DATA_W-HALF_W){1'b0}}, full_rdata[HALF_W-1:0]} : full_rdata;
  assign rvalid_o   = rvalid_q;
endmodule

// File: rtl/periph_regram_checker.sv
module periph_regram_checker
  import regram_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter logic [7:0]  VER_MAJOR = 8'd3,
  parameter logic [7:0]  VER_MINOR = 8'd7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              half_i,
  input sel_e              sel,
  input logic              ram_wr,
  input logic              ram_wen,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);
  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R8
  AST_RVALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R8
  AST_RAM_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wr |-> ram_wen); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(sel == SEL_NONE)) |-> (rdata_o == '0)); // R9
  AST_VERSION_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(sel == SEL_VER)) |-> (rdata_o == DATA_W'({VER_MAJOR, VER_MINOR}))); // R3
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(half_i)) |-> (rdata_o[DATA_W-1:DATA_W/2] == '0)); // R4
endmodule

bind periph_regram periph_regram_checker #(
  .DATA_W(DATA_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .half_i(half_i),
  .sel(sel), .ram_wr(ram_wr), .ram_wen(ram_wen), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/periph_regram_bench.sv
`timescale 1ns/1ps
module periph_regram_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic        half_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [21:0] A_CTRL = 22'h00000C;
  localparam logic [21:0] A_VER  = 22'h000040;
  localparam logic [21:0] A_SCR  = 22'h000050;
  localparam logic [21:0] A_RAM  = 22'h200000;

  always #2.5 clk_i = ~clk_i;

  periph_regram u_periph_regram (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .half_i(half_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as rvalid_o shows up
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected rvalid", rdata_o, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata_o == e, t, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; half_i = 1'b0; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    check(rvalid_o == 1'b0, "R8 no rvalid after write", {31'h0, rvalid_o}, 32'h0);
  endtask

  task automatic rd(input logic [21:0] a, input logic h, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_i = 1'b1; we_i = 1'b0; half_i = h; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0; half_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(rdata_o == 32'h0 && rvalid_o == 1'b0, "R1 outputs in reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    rd(A_CTRL, 1'b0, 32'h0, "R1 ctrl after reset");
    rd(A_SCR,  1'b0, 32'h0, "R1 scratch after reset");

    wr(A_SCR, 32'h5555_5555);
    rd(A_SCR, 1'b0, 32'h5555_5555, "R2 scratch 55");
    wr(A_SCR, 32'hAAAA_AAAA);
    rd(A_SCR, 1'b0, 32'hAAAA_AAAA, "R2 scratch AA");
    wr(A_SCR, 32'h0123_4567);
    rd(A_SCR, 1'b0, 32'h0123_4567, "R2 scratch mixed");

    rd(A_VER, 1'b0, 32'h0000_0307, "R3 version");
    wr(A_VER, 32'hFFFF_FFFF);
    rd(A_VER, 1'b0, 32'h0000_0307, "R3 version after write");
    rd(A_VER, 1'b1, 32'h0000_0307, "R4 version half read");
    rd(A_SCR, 1'b1, 32'h0000_4567, "R4 scratch half read");

    // open RAM, set other control bits too
    wr(A_CTRL, 32'hC000_10A5);
    rd(A_CTRL, 1'b0, 32'hC000_10A5, "R5 ctrl set");
    wr(A_RAM + 22'd20, 32'h1111_1111);
    wr(A_RAM, 32'hA0A0_0001);
    wr(A_RAM + 22'h3FFC, 32'hB0B0_0FFF);
    rd(A_RAM + 22'd20, 1'b0, 32'h1111_1111, "R10 ram word 5");
    rd(A_RAM, 1'b0, 32'hA0A0_0001, "R10 ram first word");
    rd(A_RAM + 22'h3FFC, 1'b0, 32'hB0B0_0FFF, "R10 ram last word");
    rd(A_RAM + 22'h3FFC, 1'b1, 32'h0000_0FFF, "R4 ram half read");

    // read-modify-write clearing bit 12
    wr(A_CTRL, 32'hC000_10A5 & 32'hFFFF_EFFF);
    rd(A_CTRL, 1'b0, 32'hC000_00A5, "R5 ctrl cleared, others kept");
    wr(A_RAM + 22'd20, 32'hDEAD_BEEF);
    wr(A_RAM, 32'h0);
    rd(A_RAM + 22'd20, 1'b0, 32'h1111_1111, "R6 protected word 5");
    rd(A_RAM, 1'b0, 32'hA0A0_0001, "R7 read while locked");

    rd(22'h000044, 1'b0, 32'h0, "R9 unmapped reg offset");
    wr(22'h000060, 32'h1234_5678);
    rd(22'h000060, 1'b0, 32'h0, "R9 unmapped write ignored");
    rd(22'h000100, 1'b0, 32'h0, "R9 outside reg window");
    rd(22'h204000, 1'b0, 32'h0, "R10 past ram end");
    rd(22'h1FFFFC, 1'b0, 32'h0, "R10 below ram base");
    rd(A_SCR, 1'b0, 32'h0123_4567, "R9 scratch untouched");

    @(negedge clk_i);
    check(rvalid_o == 1'b0, "R8 idle no rvalid", {31'h0, rvalid_o}, 32'h0);
    check(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %08h expected %08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule